// File: doc/BRIEF.md
# Real-Time Clock Calendar Update Engine

This block holds the time-of-day and calendar state of a real-time clock: seconds, minutes, hours, weekday, day of month, month, year and century, each in one byte. A host reads and writes these bytes, and a control byte, over a byte-wide register bus with a write strobe and a combinational read port.

A one-cycle `tick_1hz` pulse starts an update cycle. The update cycle lasts a fixed number of clocks, set by `UPD_CYCLES`, and `busy` is high for that whole window. When the window closes, the time has advanced by exactly one second. The carry runs from seconds into minutes and hours, then into the weekday and day of month, and on through month, year and century. The number of days in the current month, including leap Februaries, sets where the day of month wraps.

Three control bits decide how the engine behaves. One selects binary or BCD for every byte. One selects a 24-hour or 12-hour hour byte; in 12-hour form bit 7 of the hour byte is the PM flag. One freezes updates, so that software can load a consistent time.

Top module: `rtc_cal_engine`

## Requirements
- R1: After reset the eight field bytes read, at addresses 0 to 7 in this order, as seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day of month 0x01, month 0x01, year 0x00 and century 0x20. The control byte at address 8 reads 0x04, and `busy` is 0. The control byte holds bit 0 = freeze, bit 1 = binary mode (0 selects BCD) and bit 2 = 24-hour mode (0 selects 12-hour). Addresses 9 to 15 read 0.
- R2: A tick sampled while the engine is idle and not frozen raises `busy` from the next cycle for exactly `UPD_CYCLES` cycles. During that window the field bytes keep their old values. In the cycle where `busy` falls they show the time advanced by one second.
- R3: In BCD mode the full carry chain works: 23:59:59 on the 31st of December 1999 (month 0x12, year 0x99, century 0x19) becomes 00:00:00 on 0x01/0x01, year 0x00, century 0x20.
- R4: In binary mode every byte counts in plain binary: seconds 0x3B, minutes 0x3B, hour 0x17, day 0x1F, month 0x0C, year 0x63 and century 0x13 roll to 0, 0, 0, 1, 1, 0 and 0x14.
- R5: In 12-hour mode the hour counts from 1 to 12, with bit 7 as the PM flag. Hour 11 goes to 12 and toggles PM. Hour 12 goes to 1 with PM unchanged. 11 PM going to 12 AM carries into the day.
- R6: The day of month wraps after 30 in April, June, September and November, and after 31 in the other months except February.
- R7: February has 29 days when the four-digit year (century × 100 + year) is divisible by 4, except in century years not divisible by 400. So 2024 and 2000 are leap years and 2100 is not.
- R8: The weekday counts from 1 to 7, wraps from 7 to 1, and advances on every day carry.
- R9: While the freeze bit is 1, a tick starts no update: `busy` stays 0 and the fields do not change. An update whose window closes while freeze is 1 is discarded.
- R10: Host writes to field bytes while `busy` is 1 are ignored. Writes to the control byte are always accepted.
- R11: A tick that arrives while `busy` is 1 is ignored and starts no second update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address, used for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| busy | output | 1 | High while an update cycle is in progress |

## Verification
A wrong carry or limit inside the increment logic shows up at the read port as a wrong field byte. It becomes visible in the first cycle after `busy` falls following the tick that crosses that boundary. The bench therefore loads each boundary value just below its rollover and reads all affected bytes once the update window closes. A fault in the update sequencer shows up within `UPD_CYCLES` + 1 cycles as a `busy` window of the wrong length, or as fields that change early or not at all. The bench samples `busy` at the start of the window, at its last cycle and just after it.

// File: rtl/rtc_pkg.sv
// Shared constants and encoding helpers for the real-time clock calendar engine.
// Assumes every field value fits in 7 bits once decoded (0..127).
package rtc_pkg;

    localparam int NFIELD   = 8;
    localparam int SEC_IDX  = 0;
    localparam int MIN_IDX  = 1;
    localparam int HOUR_IDX = 2;
    localparam int WDAY_IDX = 3;
    localparam int MDAY_IDX = 4;
    localparam int MON_IDX  = 5;
    localparam int YEAR_IDX = 6;
    localparam int CENT_IDX = 7;
    localparam logic [3:0] CTL_ADDR = 4'd8;

    // Lowest legal value per field (index 7 down to 0).
    localparam logic [NFIELD-1:0][6:0] FLD_LO =
        {7'd0, 7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};
    // Highest legal value per field; the day-of-month entry is replaced by month length.
    localparam logic [NFIELD-1:0][6:0] FLD_HI =
        {7'd99, 7'd99, 7'd12, 7'd31, 7'd7, 7'd23, 7'd59, 7'd59};
    // Values loaded at reset.
    localparam logic [NFIELD-1:0][7:0] FLD_RST =
        {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Turn a stored byte into its numeric value under the selected encoding.
    function automatic logic [6:0] dec_val(input logic [7:0] v, input logic bin);
        if (bin) return v[6:0];
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Turn a numeric value into a stored byte under the selected encoding.
    function automatic logic [7:0] enc_val(input logic [6:0] n, input logic bin);
        if (bin) return {1'b0, n};
        return {4'(n / 7'd10), 4'(n % 7'd10)};
    endfunction

endpackage

// File: rtl/rtc_field_step.sv
// One counter stage of the carry chain: on carry-in it advances the field by one,
// or wraps it to lo when it has reached hi (any larger value also wraps).
// Assumes lo and hi are numeric values (not encoded).
module rtc_field_step
    import rtc_pkg::*;
(
    input  logic [7:0] cur,
    input  logic [6:0] lo,
    input  logic [6:0] hi,
    input  logic       bin_mode,
    input  logic       cin,
    output logic [7:0] nxt,
    output logic       cout
);
    logic [6:0] val;

    // Decode, compare against the limit, increment or wrap, and re-encode.
    always_comb begin
        val  = dec_val(cur, bin_mode);
        cout = cin && (val >= hi);
        if (!cin)
            nxt = cur;
        else if (val >= hi)
            nxt = enc_val(lo, bin_mode);
        else
            nxt = enc_val(val + 7'd1, bin_mode);
    end
endmodule

// File: rtl/rtc_hour_step.sv
// Hour stage of the carry chain, in 24-hour (0..23) or 12-hour (1..12 with PM in bit 7) form.
// In 12-hour form, 11 goes to 12 and toggles PM; the day carry fires on 11 PM -> 12 AM.
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [7:0] cur,
    input  logic       h24,
    input  logic       bin_mode,
    input  logic       cin,
    output logic [7:0] nxt,
    output logic       cout
);
    logic [6:0] val;
    logic       pm;
    logic [7:0] enc;

    // Work out the next hour byte and the day carry for both hour formats.
    always_comb begin
        pm   = cur[7];
        nxt  = cur;
        cout = 1'b0;
        enc  = 8'h00;
        if (h24) begin
            val = dec_val(cur, bin_mode);
            if (cin) begin
                if (val >= 7'd23) begin
                    nxt  = enc_val(7'd0, bin_mode);
                    cout = 1'b1;
                end else begin
                    nxt = enc_val(val + 7'd1, bin_mode);
                end
            end
        end else begin
            val = dec_val({1'b0, cur[6:0]}, bin_mode);
            if (cin) begin
                if (val == 7'd11) begin
                    enc  = enc_val(7'd12, bin_mode);
                    nxt  = {~pm, enc[6:0]};
                    cout = pm;
                end else if (val >= 7'd12) begin
                    enc = enc_val(7'd1, bin_mode);
                    nxt = {pm, enc[6:0]};
                end else begin
                    enc = enc_val(val + 7'd1, bin_mode);
                    nxt = {pm, enc[6:0]};
                end
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
// Number of days in a month, with the leap rule: the year is divisible by 4,
// and a century year (year byte 0) only when the century is divisible by 4.
// Inputs are numeric values.
module rtc_month_len (
    input  logic [6:0] mon,
    input  logic [6:0] yr,
    input  logic [6:0] cen,
    output logic [6:0] days
);
    logic leap;

    // Pick the month length from the month number and the leap test.
    always_comb begin
        leap = ((yr % 7'd4) == 7'd0) && ((yr != 7'd0) || ((cen % 7'd4) == 7'd0));
        case (mon)
            7'd2:                       days = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    days = 7'd30;
            default:                    days = 7'd31;
        endcase
    end
endmodule

// File: rtl/rtc_upd_seq.sv
// Update-cycle sequencer: an accepted tick loads a down-counter that holds busy for
// UPD_CYCLES clocks; the commit pulse fires on the last of them unless frozen.
// Assumes UPD_CYCLES >= 1. Ticks that arrive while busy are dropped.
module rtc_upd_seq #(
    parameter int UPD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(UPD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load the window on an accepted tick, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick && !freeze && (cnt == '0))
            cnt <= CW'(UPD_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy   = (cnt != '0);
    assign commit = (cnt == CW'(1)) && !freeze;
endmodule

// File: rtl/rtc_cal_engine.sv
// Real-time clock calendar engine: the field and control registers, the host
// register port, and the carry chain that advances the time by one second per
// update cycle. Assumes ticks are one-cycle pulses.
module rtc_cal_engine
    import rtc_pkg::*;
#(
    parameter int UPD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       busy
);
    logic [NFIELD-1:0][7:0] fld_q;
    logic [NFIELD-1:0][7:0] fld_nx;
    logic [2:0]             ctl_q;     // [0] freeze, [1] binary, [2] 24-hour
    logic [NFIELD-1:0]      cin_v;
    logic [NFIELD-1:0]      cout_v;
    logic [6:0]             mlen;
    logic                   commit;
    logic                   unused_carry;

    rtc_upd_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .freeze (ctl_q[0]),
        .busy   (busy),
        .commit (commit)
    );

    rtc_month_len u_mlen (
        .mon  (dec_val(fld_q[MON_IDX],  ctl_q[1])),
        .yr   (dec_val(fld_q[YEAR_IDX], ctl_q[1])),
        .cen  (dec_val(fld_q[CENT_IDX], ctl_q[1])),
        .days (mlen)
    );

    // Carry routing: seconds -> minutes -> hours -> {weekday, day} ; day -> month -> year -> century.
    assign cin_v = {cout_v[YEAR_IDX], cout_v[MON_IDX], cout_v[MDAY_IDX],
                    cout_v[HOUR_IDX], cout_v[HOUR_IDX], cout_v[MIN_IDX],
                    cout_v[SEC_IDX], 1'b1};
    assign unused_carry = cout_v[WDAY_IDX] | cout_v[CENT_IDX];

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        if (i == HOUR_IDX) begin : g_hour
            rtc_hour_step u_step (
                .cur      (fld_q[i]),
                .h24      (ctl_q[2]),
                .bin_mode (ctl_q[1]),
                .cin      (cin_v[i]),
                .nxt      (fld_nx[i]),
                .cout     (cout_v[i])
            );
        end else begin : g_cnt
            logic [6:0] hi_i;
            assign hi_i = (i == MDAY_IDX) ? mlen : FLD_HI[i];
            rtc_field_step u_step (
                .cur      (fld_q[i]),
                .lo       (FLD_LO[i]),
                .hi       (hi_i),
                .bin_mode (ctl_q[1]),
                .cin      (cin_v[i]),
                .nxt      (fld_nx[i]),
                .cout     (cout_v[i])
            );
        end
    end

    // Field registers: the update commit wins; host writes land only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fld_q <= FLD_RST;
        else if (commit)
            fld_q <= fld_nx;
        else if (bus_we && !busy && !bus_addr[3])
            fld_q[bus_addr[2:0]] <= bus_wdata;
    end

    // Control register: host writes are accepted at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 3'b100;
        else if (bus_we && (bus_addr == CTL_ADDR))
            ctl_q <= bus_wdata[2:0];
    end

    // Read mux over the field and control registers.
    always_comb begin
        if (!bus_addr[3])
            bus_rdata = fld_q[bus_addr[2:0]];
        else if (bus_addr == CTL_ADDR)
            bus_rdata = {5'b0, ctl_q};
        else
            bus_rdata = 8'h00;
    end
endmodule

// File: rtl/rtc_cal_engine_chk.sv
// Assertion checker for rtc_cal_engine, bound to every instance of the top.
// Watches the update window, the freeze control and the field registers.
module rtc_cal_engine_chk
    import rtc_pkg::*;
#(
    parameter int UPD_CYCLES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_1hz,
    input logic                   bus_we,
    input logic                   busy,
    input logic [2:0]             ctl,
    input logic [NFIELD-1:0][7:0] fld
);
    logic [15:0] run;

    // Length of the current busy window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else
            run <= busy ? run + 16'd1 : 16'd0;
    end

    // R2
    upd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !busy && !ctl[0]) |=> busy);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < 16'(UPD_CYCLES)));

    // R2
    upd_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctl[0])) |-> (fld != $past(fld)));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && !bus_we) |=> $stable(fld));
endmodule

bind rtc_cal_engine rtc_cal_engine_chk #(.UPD_CYCLES(UPD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .bus_we   (bus_we),
    .busy     (busy),
    .ctl      (ctl_q),
    .fld      (fld_q)
);

// File: tb/sim_rtc_cal_engine.sv
module sim_rtc_cal_engine;
    localparam int UPD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_busy;
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    rtc_cal_engine #(.UPD_CYCLES(UPD)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy)
    );

    // Driver side: push an expected register value and wait until the monitor has compared it.
    task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_busy = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    // Driver side: push an expected busy level, sampled without waiting for an edge.
    task automatic exp_busy(input logic e, input string tag);
        item_t it;
        it.is_busy = 1'b1; it.addr = 4'd0; it.exp = {7'd0, e}; it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    // Monitor: pop expected items, sample the port and compare.
    initial begin
        logic [7:0] act;
        forever begin
            wait (sbq.size() > 0);
            if (!sbq[0].is_busy) begin
                @(negedge clk);
                bus_addr = sbq[0].addr;
            end
            #1;
            act = sbq[0].is_busy ? {7'd0, busy} : bus_rdata;
            checks++;
            if (act !== sbq[0].exp) begin
                errors++;
                $display("FAIL %s addr %0d: actual %h expected %h",
                         sbq[0].tag, sbq[0].addr, act, sbq[0].exp);
            end
            void'(sbq.pop_front());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // One tick, then wait until the update window has closed.
    task automatic do_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (UPD) @(negedge clk);
    endtask

    // Load 23:59:59 in 24-hour BCD on a given date.
    task automatic load_eod(input logic [7:0] cen, input logic [7:0] yr,
                            input logic [7:0] mon, input logic [7:0] day);
        wr(4'd8, 8'h04);
        wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
        wr(4'd4, day); wr(4'd5, mon); wr(4'd6, yr); wr(4'd7, cen);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        exp_busy(1'b0, "R1");
        exp_rd(4'd0, 8'h00, "R1"); exp_rd(4'd1, 8'h00, "R1");
        exp_rd(4'd2, 8'h00, "R1"); exp_rd(4'd3, 8'h01, "R1");
        exp_rd(4'd4, 8'h01, "R1"); exp_rd(4'd5, 8'h01, "R1");
        exp_rd(4'd6, 8'h00, "R1"); exp_rd(4'd7, 8'h20, "R1");
        exp_rd(4'd8, 8'h04, "R1"); exp_rd(4'd12, 8'h00, "R1");

        // R2: busy window length, fields hold until it closes
        wr(4'd0, 8'h41);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        exp_busy(1'b1, "R2");
        exp_rd(4'd0, 8'h41, "R2");
        repeat (UPD - 2) @(negedge clk);
        exp_busy(1'b1, "R2");
        @(negedge clk);
        exp_busy(1'b0, "R2");
        exp_rd(4'd0, 8'h42, "R2");

        // R3, R8: full BCD carry chain, weekday wrap 7 -> 1
        load_eod(8'h19, 8'h99, 8'h12, 8'h31);
        wr(4'd3, 8'h07);
        do_tick();
        exp_rd(4'd0, 8'h00, "R3"); exp_rd(4'd1, 8'h00, "R3");
        exp_rd(4'd2, 8'h00, "R3"); exp_rd(4'd4, 8'h01, "R3");
        exp_rd(4'd5, 8'h01, "R3"); exp_rd(4'd6, 8'h00, "R3");
        exp_rd(4'd7, 8'h20, "R3"); exp_rd(4'd3, 8'h01, "R8");

        // R4: binary mode rollover of every field
        wr(4'd8, 8'h06);
        wr(4'd0, 8'h3B); wr(4'd1, 8'h3B); wr(4'd2, 8'h17);
        wr(4'd4, 8'h1F); wr(4'd5, 8'h0C); wr(4'd6, 8'h63); wr(4'd7, 8'h13);
        do_tick();
        exp_rd(4'd0, 8'h00, "R4"); exp_rd(4'd1, 8'h00, "R4");
        exp_rd(4'd2, 8'h00, "R4"); exp_rd(4'd4, 8'h01, "R4");
        exp_rd(4'd5, 8'h01, "R4"); exp_rd(4'd6, 8'h00, "R4");
        exp_rd(4'd7, 8'h14, "R4");

        // R5: 12-hour transitions in BCD
        wr(4'd8, 8'h00);
        wr(4'd5, 8'h05); wr(4'd4, 8'h10); wr(4'd3, 8'h03);
        wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h11);
        do_tick();
        exp_rd(4'd2, 8'h92, "R5"); exp_rd(4'd4, 8'h10, "R5");
        wr(4'd0, 8'h59); wr(4'd1, 8'h59);
        do_tick();
        exp_rd(4'd2, 8'h81, "R5");
        wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h91);
        do_tick();
        exp_rd(4'd2, 8'h12, "R5"); exp_rd(4'd4, 8'h11, "R5");
        exp_rd(4'd3, 8'h04, "R8");

        // R6: 30-day month
        load_eod(8'h20, 8'h23, 8'h04, 8'h30);
        do_tick();
        exp_rd(4'd4, 8'h01, "R6"); exp_rd(4'd5, 8'h05, "R6");
        load_eod(8'h20, 8'h23, 8'h05, 8'h30);
        do_tick();
        exp_rd(4'd4, 8'h31, "R6"); exp_rd(4'd5, 8'h05, "R6");

        // R7: leap years
        load_eod(8'h20, 8'h24, 8'h02, 8'h28);
        do_tick();
        exp_rd(4'd4, 8'h29, "R7"); exp_rd(4'd5, 8'h02, "R7");
        wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
        do_tick();
        exp_rd(4'd4, 8'h01, "R7"); exp_rd(4'd5, 8'h03, "R7");
        load_eod(8'h21, 8'h00, 8'h02, 8'h28);
        do_tick();
        exp_rd(4'd4, 8'h01, "R7"); exp_rd(4'd5, 8'h03, "R7");
        load_eod(8'h20, 8'h00, 8'h02, 8'h28);
        do_tick();
        exp_rd(4'd4, 8'h29, "R7");

        // R9: freeze blocks ticks
        wr(4'd8, 8'h05);
        wr(4'd0, 8'h20);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        exp_busy(1'b0, "R9");
        repeat (UPD) @(negedge clk);
        exp_rd(4'd0, 8'h20, "R9");
        wr(4'd8, 8'h04);
        do_tick();
        exp_rd(4'd0, 8'h21, "R9");

        // R10: field write during busy ignored
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h30;
        @(negedge clk); bus_we = 1'b0;
        repeat (UPD - 1) @(negedge clk);
        exp_rd(4'd0, 8'h22, "R10");

        // R10, R9: control write during busy accepted and discards the pending update
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h05;
        @(negedge clk); bus_we = 1'b0;
        repeat (UPD - 1) @(negedge clk);
        exp_rd(4'd0, 8'h22, "R9");
        exp_rd(4'd8, 8'h05, "R10");
        wr(4'd8, 8'h04);

        // R11: tick during busy ignored
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk);
        @(negedge clk); tick_1hz = 1'b0;
        repeat (UPD - 1) @(negedge clk);
        exp_rd(4'd0, 8'h23, "R11");
        exp_busy(1'b0, "R11");
        repeat (UPD + 2) @(negedge clk);
        exp_rd(4'd0, 8'h23, "R11");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule